// File: doc/BRIEF.md
# Looping Square-Wave Music Player with Effect Overlay

The block plays a short built-in melody, one note after another, with no help from software. Each step of the melody is a stored word that holds a pitch index and a length. The pitch index is turned into a phase step through a computed frequency table. A 24-bit phase accumulator then produces a square wave whose top bit sets the tone. A new 8-bit sample comes out at 50 kHz. The block also makes the sample clock for an external converter and drives it on a pin. Sample data changes only as that clock falls, so the converter can capture it on the rising edge.

Game logic can request a short sound effect at any time by giving a 2-bit code. The effect runs on a second tone channel for a length set by its code and is added on top of the melody. Each channel is scaled to half of full range, so their sum always fits in 8 bits. When the enable is low the melody is silent and held at its first step, but effects still sound.

Top module: `music_synth`

## Requirements
- R1: One sample period lasts DIV = CLK_HZ/SAMPLE_HZ clock cycles, which is 50 kHz with the defaults. `dac_clk_o` is high for the first DIV/2 cycles of each period and low for the remaining DIV/2.
- R2: `sample_o` changes only in the clock cycle in which `dac_clk_o` falls. That falling edge is the sample tick.
- R3: Each sequence word is {note[5:0], dur[3:0]}. The word plays for (dur+1)*SIXTEENTH_SAMPLES ticks, and then the next word starts. The next word is address 0 when the word after the current one carries note 63, the end marker. The built-in melody is (58,1) (0,0) (62,2) (61,0) (50,3) (55,1), given as (note,dur), with the end marker at address 6.
- R4: The music accumulator is cleared when a word starts. It then grows by inc(n) after each tick, where inc(n) = K[(n-1) mod 12] >> (5 - (n-1)/12). K is 702295, 744056, 788300, 835176, 884836, 937453, 993197, 1052252, 1114825, 1181115, 1251348, 1325758. The music channel is high while accumulator bit 23 is 1.
- R5: A word with note 0 is a rest. During a rest the music channel contributes 0.
- R6: At each tick the sample equals (music high ? 127 : 0) + (effect high ? 127 : 0). These levels come from the accumulator values held before that tick's advance. The sample is therefore always 0, 127 or 254.
- R7: At each tick taken while `en` is low, the music channel contributes 0, the sequence returns to address 0 and the music accumulator is cleared. When `en` goes high again, the melody starts fresh from address 0. Effects are not affected by `en`.
- R8: A pulse on `fx_req` with code c clears the effect accumulator and arms the effect for FX_TICKS*(c+1) ticks, with step K[3c]. A request made while an effect is playing restarts it. The effect channel is high while its accumulator bit 23 is 1 and the effect is armed. After the effect's ticks have run out, it contributes 0.
- R9: After reset, `sample_o` is 0 and `dac_clk_o` is 1. The sequence is at address 0 and no effect is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Music enable |
| fx_req | input | 1 | One-cycle effect request |
| fx_code | input | 2 | Effect selector, sampled with the request |
| sample_o | output | 8 | Unsigned sample for the converter |
| dac_clk_o | output | 1 | Sample clock for the converter |

## Verification
The bench plays the whole melody more than three times, so every word, both end-marker wraps, the rests and notes from several octaves all appear. Each tick is compared with a model worked out from the stated table. A window with `en` low while an effect plays separates muting of the melody from muting of the effect. Re-enabling shows whether the melody restarts at address 0. Every effect code is then tried with a restart in mid-effect, which tells a restart apart from one that is ignored or added to the time left. Throughout the run, the duty cycle of the sample clock is measured and every change of the data is checked against the clock's falling edge.

// File: rtl/music_synth.sv
module music_synth #(
  parameter int CLK_HZ            = 50_000_000,
  parameter int SAMPLE_HZ         = 50_000,
  parameter int SIXTEENTH_SAMPLES = 6250,
  parameter int FX_TICKS          = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fx_req,
  input  logic [1:0] fx_code,
  output logic [7:0] sample_o,
  output logic       dac_clk_o
);
  localparam int DIV  = CLK_HZ / SAMPLE_HZ;
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int RW   = $clog2(16 * SIXTEENTH_SAMPLES + 1);
  localparam int FW   = $clog2(4 * FX_TICKS + 1);
  localparam logic [5:0] END_NOTE = 6'd63;

  function automatic logic [9:0] song(input logic [2:0] a);
    case (a)
      3'd0:    song = {6'd58, 4'd1};
      3'd1:    song = {6'd0,  4'd0};
      3'd2:    song = {6'd62, 4'd2};
      3'd3:    song = {6'd61, 4'd0};
      3'd4:    song = {6'd50, 4'd3};
      3'd5:    song = {6'd55, 4'd1};
      default: song = {END_NOTE, 4'd0};
    endcase
  endfunction

  function automatic logic [23:0] top_step(input logic [3:0] s);
    case (s)
      4'd0:    top_step = 24'd702295;
      4'd1:    top_step = 24'd744056;
      4'd2:    top_step = 24'd788300;
      4'd3:    top_step = 24'd835176;
      4'd4:    top_step = 24'd884836;
      4'd5:    top_step = 24'd937453;
      4'd6:    top_step = 24'd993197;
      4'd7:    top_step = 24'd1052252;
      4'd8:    top_step = 24'd1114825;
      4'd9:    top_step = 24'd1181115;
      4'd10:   top_step = 24'd1251348;
      4'd11:   top_step = 24'd1325758;
      default: top_step = 24'd0;
    endcase
  endfunction

  function automatic logic [23:0] note_step(input logic [5:0] n);
    logic [5:0] m;
    m = n - 6'd1;
    if (n == 6'd0 || n == END_NOTE) note_step = 24'd0;
    else note_step = top_step(4'(m % 6'd12)) >> (3'd5 - 3'(m / 6'd12));
  endfunction

  function automatic logic [RW-1:0] note_len(input logic [3:0] d);
    note_len = RW'((int'(d) + 1) * SIXTEENTH_SAMPLES);
  endfunction

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          tick;
  assign cnt_nxt = (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
  assign tick    = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      dac_clk_o <= 1'b1;
    end else begin
      cnt       <= cnt_nxt;
      dac_clk_o <= (cnt_nxt < CW'(HALF));
    end
  end

  logic [2:0]    addr;
  logic [2:0]    addr_nxt;
  logic [RW-1:0] rem;
  logic [23:0]   macc;
  logic [9:0]    cur;
  assign cur      = song(addr);
  assign addr_nxt = (song(3'(addr + 3'd1)) >> 4 == 10'(END_NOTE)) ? 3'd0 : 3'(addr + 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || (tick && !en)) begin
      addr <= 3'd0;
      rem  <= note_len(song(3'd0) [3:0]);
      macc <= '0;
    end else if (tick) begin
      if (rem == RW'(1)) begin
        addr <= addr_nxt;
        rem  <= note_len(song(addr_nxt) [3:0]);
        macc <= '0;
      end else begin
        rem  <= rem - RW'(1);
        macc <= macc + note_step(cur[9:4]);
      end
    end
  end

  logic [FW-1:0] frem;
  logic [23:0]   facc;
  logic [23:0]   finc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frem <= '0;
      facc <= '0;
      finc <= '0;
    end else if (fx_req) begin
      frem <= FW'(FX_TICKS * (int'(fx_code) + 1));
      facc <= '0;
      finc <= top_step(4'({2'b00, fx_code} * 4'd3));
    end else if (tick && frem != '0) begin
      frem <= frem - FW'(1);
      facc <= facc + finc;
    end
  end

  logic mus_hi;
  logic fx_hi;
  assign mus_hi = en && (cur[9:4] != 6'd0) && macc[23];
  assign fx_hi  = (frem != '0) && facc[23];

  always_ff @(posedge clk) begin
    if (!rst_n) sample_o <= 8'd0;
    else if (tick) sample_o <= {1'b0, {7{mus_hi}}} + {1'b0, {7{fx_hi}}};
  end

  a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_o) |-> $fell(dac_clk_o));

  a_r6_levels: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o == 8'd0 || sample_o == 8'd127 || sample_o == 8'd254);

  a_r3_no_marker: assert property (@(posedge clk) disable iff (!rst_n)
    cur[9:4] != END_NOTE);

  a_r5_rest_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && cur[9:4] == 6'd0 && frem == '0) |=> sample_o == 8'd0);

  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en && frem == '0) |=> sample_o == 8'd0);

  a_r8_fx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frem == '0) |=> (sample_o == 8'd0 || sample_o == 8'd127));
endmodule

// File: tb/music_synth_tb.sv
`timescale 1ns/1ps
module music_synth_tb;
  localparam int CLK_HZ = 400_000;
  localparam int SAMPLE_HZ = 50_000;
  localparam int DIV = CLK_HZ / SAMPLE_HZ;
  localparam int HALF = DIV / 2;
  localparam int SIX = 16;
  localparam int FXT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic fx_req = 1'b0;
  logic [1:0] fx_code = 2'd0;
  logic [7:0] sample_o;
  logic dac_clk_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  music_synth #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ),
                .SIXTEENTH_SAMPLES(SIX), .FX_TICKS(FXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fx_req(fx_req), .fx_code(fx_code),
    .sample_o(sample_o), .dac_clk_o(dac_clk_o));

  int k_tab [12] = '{702295, 744056, 788300, 835176, 884836, 937453,
                     993197, 1052252, 1114825, 1181115, 1251348, 1325758};
  int s_note [7] = '{58, 0, 62, 61, 50, 55, 63};
  int s_dur  [7] = '{1, 0, 2, 0, 3, 1, 0};

  int m_addr;
  int m_rem;
  logic [23:0] m_acc;
  int f_rem;
  logic [23:0] f_acc;
  logic [23:0] f_inc;

  function automatic logic [23:0] step_of(int n);
    if (n == 0) return 24'd0;
    return 24'(k_tab[(n - 1) % 12] >> (5 - (n - 1) / 12));
  endfunction

  function automatic int len_of(int a);
    return (s_dur[a] + 1) * SIX;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      bit em;
      bit ef;
      int nx;
      string tag;
      @(negedge dac_clk_o);
      #1;
      em = en && s_note[m_addr] != 0 && m_acc[23];
      ef = f_rem != 0 && f_acc[23];
      if (f_rem != 0 && en && s_note[m_addr] != 0) tag = "R6 mixed sample";
      else if (f_rem != 0) tag = "R8 effect sample";
      else if (!en) tag = "R7 disabled sample";
      else if (m_rem == len_of(m_addr)) tag = "R3 first sample of word";
      else if (s_note[m_addr] == 0) tag = "R5 rest sample";
      else tag = "R4 tone sample";
      check(tag, int'(sample_o), (em ? 127 : 0) + (ef ? 127 : 0));
      if (!en) begin
        m_addr = 0; m_rem = len_of(0); m_acc = 0;
      end else if (m_rem == 1) begin
        nx = (s_note[m_addr + 1] == 63) ? 0 : m_addr + 1;
        m_addr = nx; m_rem = len_of(nx); m_acc = 0;
      end else begin
        m_rem--; m_acc = m_acc + step_of(s_note[m_addr]);
      end
      if (f_rem != 0) begin
        f_rem--; f_acc = f_acc + f_inc;
      end
    end
  endtask

  task automatic pulse_fx(int c);
    @(negedge clk);
    fx_code = 2'(c);
    fx_req = 1'b1;
    @(negedge clk);
    fx_req = 1'b0;
    f_rem = FXT * (c + 1);
    f_acc = 0;
    f_inc = 24'(k_tab[3 * c]);
  endtask

  bit prev_d = 1'b1;
  logic [7:0] prev_s = 8'd0;
  bit seen_rise = 1'b0;
  int hi_run = 0;
  int lo_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_d && !dac_clk_o) begin
        if (seen_rise) check("R1 high phase length", hi_run, HALF);
        lo_run = 1;
      end else if (!prev_d && dac_clk_o) begin
        check("R1 low phase length", lo_run, HALF);
        seen_rise = 1'b1;
        hi_run = 1;
      end else if (dac_clk_o) hi_run++;
      else lo_run++;
      if (sample_o != prev_s)
        check("R2 data change on falling clock", int'(prev_d && !dac_clk_o), 1);
      prev_d = dac_clk_o;
      prev_s = sample_o;
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_addr = 0; m_rem = len_of(0); m_acc = 0;
    f_rem = 0; f_acc = 0; f_inc = 0;
    repeat (5) @(negedge clk);
    check("R9 reset sample", int'(sample_o), 0);
    check("R9 reset dac clock", int'(dac_clk_o), 1);
    rst_n = 1'b1;
    run(650);
    en = 1'b0;
    pulse_fx(1);
    run(45);
    en = 1'b1;
    run(100);
    for (int c = 0; c < 4; c++) begin
      pulse_fx(c);
      run(10 + 5 * c);
      pulse_fx(c);
      run(FXT * (c + 1) + 5);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule